// File: doc/BRIEF.md
# Error-Correcting Static Memory with Byte Lanes

This block is a clocked on-chip memory whose host side resembles a classic asynchronous static RAM: an active-low select, a second active-high select, a write strobe, an output strobe and two active-low byte-lane strobes. Every 16-bit word is held as a 22-bit codeword protected by a single-error-correcting, double-error-detecting code. A one-bit fault anywhere in the codeword is repaired before the data leaves the block, and a pulse on a flag output reports it. A two-bit fault is reported on a second flag, and the uncorrected data is returned.

A mode input switches the host view between 16-bit words and 8-bit bytes. In byte view the lowest address bit chooses the lane. Every write that does not cover both lanes is a read-modify-write of the whole codeword, so the check bits always describe the full stored word. Reads never repair the array. A fault stays in place until that word is written again. A fault-injection port XORs a mask into a stored codeword so that tests can create faults on purpose.

Controls are sampled on the rising clock edge. Read data and the fault flags appear in the cycle after a qualified read. The data bus is split into an input, an output and an output-drive qualifier. A low qualifier stands for a high-impedance bus.

Top module: `ecc_sram`

## Requirements
- R1: The block is selected only when `sel_n` is 0 and `sel` is 1 at the same edge. At any other edge nothing is stored, and `dq_drive` is 0 in the following cycle.
- R2: In word view (`byte_mode`=0), a selected edge with `wr_n`=0 stores `dq_in[15:8]` when `ub_n`=0 and `dq_in[7:0]` when `lb_n`=0. A lane whose strobe is 1 keeps its previous value. The word index is `addr[AW-1:0]`.
- R3: A selected edge with `wr_n`=1 and `rd_n`=0 is a qualified read. In the next cycle `dq_drive` is 1 and `dq_out` shows the word. In word view, a lane whose strobe is 1 reads as 0. After any other edge, `dq_drive` is 0.
- R4: At a selected edge with `wr_n`=0, `rd_n` is ignored, and `dq_drive` and both flags are 0 in the following cycle.
- R5: If the stored codeword differs from a valid one in exactly one bit, a read returns the corrected data, and `err_fix` is 1 for that one output cycle, with `err_bad` at 0.
- R6: If the stored codeword differs in exactly two bits, a read raises `err_bad` for one cycle with `err_fix` at 0. `dq_out` then carries the data bits of the faulty codeword as stored.
- R7: In byte view (`byte_mode`=1), the word index is `addr[AW:1]`, and `addr[0]`=0 selects bits 7:0 while `addr[0]`=1 selects bits 15:8. Writes take `dq_in[7:0]`. Reads return the chosen byte on `dq_out[7:0]` with `dq_out[15:8]`=0. `ub_n` and `lb_n` are ignored.
- R8: A write that covers only one lane first corrects a one-bit fault in the old word, then merges the new lane in and stores a fresh codeword. A later read shows no flag and both lanes hold their correct values.
- R9: Reads never write corrected data back. Repeated reads of a word with a one-bit fault each raise `err_fix`.
- R10: `inj_en`=1 at an edge XORs `inj_mask` into the codeword at the current word index, and the host access in that edge is ignored (`dq_drive` is 0 next). Codeword layout: bit 0 is overall parity. Bits 1 to 21 are code positions 1 to 21. Positions 1, 2, 4, 8 and 16 hold check bits. Data bits 0 to 15 fill the remaining positions in ascending order.
- R11: After reset `dq_drive`, `err_fix` and `err_bad` are 0, and every word reads as 0x0000 without a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Select, active low |
| sel | input | 1 | Select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Output strobe, active low |
| ub_n | input | 1 | Upper lane strobe (bits 15:8), active low |
| lb_n | input | 1 | Lower lane strobe (bits 7:0), active low |
| byte_mode | input | 1 | 1 = 8-bit byte view, 0 = 16-bit word view |
| addr | input | AW+1 | Address; AW = clog2(DEPTH) |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, valid while dq_drive is 1 |
| dq_drive | output | 1 | Bus drive qualifier; 0 means high impedance |
| err_fix | output | 1 | One-bit fault corrected in this read cycle |
| err_bad | output | 1 | Two-bit fault detected in this read cycle |
| inj_en | input | 1 | Apply fault mask at this edge |
| inj_mask | input | 22 | Bits XORed into the stored codeword |

## Verification
A faulty correction path shows at the ports in the cycle right after the read of an injected word, as wrong data or a wrong flag. A faulty check-bit encoder stays hidden until the next read of the word it wrote, which then shows a spurious flag. A read-modify-write that merges uncorrected data leaves a bad lane behind, and only a read after the partial write reveals it. Any scrubbing or write-back on reads turns up on the second read of a faulty word, as a missing flag.

// File: rtl/ecc_sram_pkg.sv
// Shared widths and SECDED helpers for the ECC static memory.
// Assumes 16 data bits in positions 1..21 (non powers of two) and an
// overall parity bit in codeword bit 0.
package ecc_sram_pkg;
    localparam int DATA_W = 16;
    localparam int HAM_W  = 5;
    localparam int POS_N  = DATA_W + HAM_W;   // code positions 1..POS_N
    localparam int CODE_W = POS_N + 1;        // plus overall parity

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fix;
        logic              bad;
    } dec_t;

    // Build a codeword from a data word.
    function automatic logic [CODE_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        logic              x;
        int                k;
        c = '0;
        k = 0;
        for (int p = 1; p <= POS_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < HAM_W; b++) begin
            x = 1'b0;
            for (int p = 1; p <= POS_N; p++) begin
                if (((p >> b) & 1) == 1 && (p & (p - 1)) != 0) x ^= c[p];
            end
            c[1 << b] = x;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    // Check a codeword, correct one flip, flag two flips.
    function automatic dec_t secded_dec(input logic [CODE_W-1:0] c);
        dec_t              r;
        logic [HAM_W-1:0]  syn;
        logic              ov;
        logic [CODE_W-1:0] f;
        int                k;
        syn = '0;
        for (int p = 1; p <= POS_N; p++) begin
            if (c[p]) syn ^= HAM_W'(p);
        end
        ov    = ^c;
        f     = c;
        r.fix = 1'b0;
        r.bad = 1'b0;
        if (ov) begin
            if (int'(syn) <= POS_N) begin
                f[syn] = ~f[syn];
                r.fix  = 1'b1;
            end else begin
                r.bad = 1'b1;
            end
        end else if (syn != '0) begin
            r.bad = 1'b1;
        end
        if (r.bad) f = c;
        k = 0;
        r.data = '0;
        for (int p = 1; p <= POS_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[k] = f[p];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
// Check-bit encoder: turns a 16-bit word into a 22-bit codeword.
// Purely combinational; assumes the layout fixed in ecc_sram_pkg.
module ecc_sram_enc
    import ecc_sram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    // Encode the incoming word.
    always_comb code_o = secded_enc(data_i);
endmodule

// File: rtl/ecc_sram_dec.sv
// Codeword checker: corrects a single flipped bit and flags a double flip.
// On a double flip the data bits are passed through unchanged.
module ecc_sram_dec
    import ecc_sram_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fix_o,
    output logic              bad_o
);
    dec_t res;

    // Run the syndrome check and split the result.
    always_comb begin
        res    = secded_dec(code_i);
        data_o = res.data;
        fix_o  = res.fix;
        bad_o  = res.bad;
    end
endmodule

// File: rtl/ecc_sram.sv
// ECC-protected static memory with a strobe-style host side.
// Controls are sampled at the rising edge; reads return one cycle later.
// Partial writes read, correct, merge and re-encode the whole word.
// Assumes DEPTH is a power of two and the array fits in flops.
module ecc_sram
    import ecc_sram_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LANE = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              byte_mode,
    input  logic [AW:0]       addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              err_fix,
    output logic              err_bad,
    input  logic              inj_en,
    input  logic [CODE_W-1:0] inj_mask
);
    logic [CODE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     widx;
    logic [CODE_W-1:0] cw_old, cw_new;
    logic [DATA_W-1:0] old_data, merged, rd_view;
    logic              old_fix, old_bad;
    logic              picked, lane_hi, lane_lo;
    logic              do_wr, do_rd;

    // Word index and selection qualifiers.
    always_comb begin
        picked  = !sel_n && sel;
        widx    = byte_mode ? addr[AW:1] : addr[AW-1:0];
        lane_hi = byte_mode ? addr[0]  : !ub_n;
        lane_lo = byte_mode ? !addr[0] : !lb_n;
        do_wr   = !inj_en && picked && !wr_n && (lane_hi || lane_lo);
        do_rd   = !inj_en && picked && wr_n && !rd_n;
        cw_old  = mem[widx];
    end

    ecc_sram_dec u_dec (
        .code_i (cw_old),
        .data_o (old_data),
        .fix_o  (old_fix),
        .bad_o  (old_bad)
    );

    // Merge enabled lanes into the checked old word.
    always_comb begin
        merged[DATA_W-1:LANE] = lane_hi ? (byte_mode ? dq_in[LANE-1:0] : dq_in[DATA_W-1:LANE])
                                        : old_data[DATA_W-1:LANE];
        merged[LANE-1:0]      = lane_lo ? dq_in[LANE-1:0] : old_data[LANE-1:0];
    end

    ecc_sram_enc u_enc (
        .data_i (merged),
        .code_o (cw_new)
    );

    // Shape the read data for the current view.
    always_comb begin
        if (byte_mode) begin
            rd_view = {{LANE{1'b0}}, addr[0] ? old_data[DATA_W-1:LANE] : old_data[LANE-1:0]};
        end else begin
            rd_view[DATA_W-1:LANE] = ub_n ? '0 : old_data[DATA_W-1:LANE];
            rd_view[LANE-1:0]      = lb_n ? '0 : old_data[LANE-1:0];
        end
    end

    // Array update: clear on reset, fault injection, or re-encoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (inj_en) begin
            mem[widx] <= cw_old ^ inj_mask;
        end else if (do_wr) begin
            mem[widx] <= cw_new;
        end
    end

    // Registered read port and fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out   <= '0;
            dq_drive <= 1'b0;
            err_fix  <= 1'b0;
            err_bad  <= 1'b0;
        end else begin
            dq_out   <= do_rd ? rd_view : '0;
            dq_drive <= do_rd;
            err_fix  <= do_rd && old_fix;
            err_bad  <= do_rd && old_bad;
        end
    end

    // R1: an unselected edge never leads to a driven bus.
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel) |=> !dq_drive);

    // R3: a qualified read always drives the bus next cycle.
    p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel && wr_n && !rd_n && !inj_en) |=> dq_drive);

    // R4: a write cycle leaves the bus undriven whatever rd_n says.
    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel && !wr_n) |=> (!dq_drive && !err_fix && !err_bad));

    // R5: corrected and uncorrectable flags never coincide.
    p_flags_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_fix && err_bad));

    // R6: a fault flag only appears alongside driven read data.
    p_flag_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_fix || err_bad) |-> dq_drive);

    // R10: an injection edge suppresses the host access.
    p_inject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |=> !dq_drive);
endmodule

// File: tb/ecc_sram_tb.sv
`timescale 1ns/100ps
module ecc_sram_tb;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic        ub_n = 1'b1, lb_n = 1'b1, byte_mode = 1'b0, inj_en = 1'b0;
    logic [AW:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [21:0] inj_mask = '0;
    logic [15:0] dq_out;
    logic        dq_drive, err_fix, err_bad;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_data [DEPTH];
    logic [21:0] m_mask [DEPTH];

    always #2.5 clk = ~clk;

    ecc_sram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .wr_n(wr_n),
        .rd_n(rd_n), .ub_n(ub_n), .lb_n(lb_n), .byte_mode(byte_mode),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive),
        .err_fix(err_fix), .err_bad(err_bad), .inj_en(inj_en), .inj_mask(inj_mask)
    );

    // Codeword position of data bit k (R10 layout).
    function automatic int pos_of(input int k);
        int n = 0;
        for (int p = 1; p <= 21; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == k) return p;
                n++;
            end
        end
        return 0;
    endfunction

    // Data bits as stored after a fault mask is applied.
    function automatic logic [15:0] raw_of(input logic [15:0] d, input logic [21:0] m);
        logic [15:0] r = d;
        for (int k = 0; k < 16; k++) if (m[pos_of(k)]) r[k] = ~r[k];
        return r;
    endfunction

    function automatic int ones(input logic [21:0] m);
        int n = 0;
        for (int i = 0; i < 22; i++) n += int'(m[i]);
        return n;
    endfunction

    // One edge of stimulus with prediction and check of the next cycle.
    task automatic do_op(input logic c1n, input logic c2, input logic wn, input logic on,
                         input logic ubn, input logic lbn, input logic bm,
                         input logic [AW:0] a, input logic [15:0] din,
                         input logic inj, input logic [21:0] im, input string tag);
        logic        pk, hi, lo, ew, er, ef, eb;
        logic [15:0] od, ed, nw;
        int          wi, nb;
        string       t;
        pk = !c1n && c2;
        wi = bm ? int'(a[AW:1]) : int'(a[AW-1:0]);
        hi = bm ? a[0] : !ubn;
        lo = bm ? !a[0] : !lbn;
        nb = ones(m_mask[wi]);
        od = (nb == 2) ? raw_of(m_data[wi], m_mask[wi]) : m_data[wi];
        ew = !inj && pk && !wn && (hi || lo);
        er = !inj && pk && wn && !on;
        ef = er && (nb == 1);
        eb = er && (nb == 2);
        if (bm) ed = {8'h00, a[0] ? od[15:8] : od[7:0]};
        else    ed = {ubn ? 8'h00 : od[15:8], lbn ? 8'h00 : od[7:0]};
        t = tag;
        if (t == "") begin
            if (inj) t = "R10";
            else if (!pk) t = "R1";
            else if (!wn) t = "R4";
            else if (ef) t = "R5";
            else if (eb) t = "R6";
            else if (er && bm) t = "R7";
            else t = "R3";
        end
        sel_n = c1n; sel = c2; wr_n = wn; rd_n = on; ub_n = ubn; lb_n = lbn;
        byte_mode = bm; addr = a; dq_in = din; inj_en = inj; inj_mask = im;
        if (inj) m_mask[wi] = m_mask[wi] ^ im;
        else if (ew) begin
            nw[15:8] = hi ? (bm ? din[7:0] : din[15:8]) : od[15:8];
            nw[7:0]  = lo ? din[7:0] : od[7:0];
            m_data[wi] = nw;
            m_mask[wi] = '0;
        end
        @(negedge clk);
        n_chk++;
        if (dq_drive !== er || err_fix !== ef || err_bad !== eb || (er && dq_out !== ed)) begin
            n_fail++;
            $display("FAIL %s: drive/data/fix/bad actual %b/%h/%b/%b expected %b/%h/%b/%b",
                     t, dq_drive, dq_out, err_fix, err_bad, er, ed, ef, eb);
        end
    endtask

    task automatic wr_word(input int w, input logic [15:0] d, input logic ubn, input logic lbn, input string tag);
        do_op(1'b0, 1'b1, 1'b0, 1'b1, ubn, lbn, 1'b0, (AW+1)'(w), d, 1'b0, '0, tag);
    endtask

    task automatic rd_word(input int w, input string tag);
        do_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, (AW+1)'(w), 16'h0, 1'b0, '0, tag);
    endtask

    task automatic inject(input int w, input logic [21:0] m);
        do_op(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, (AW+1)'(w), 16'h0, 1'b1, m, "R10");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [21:0] m;
        int          w, b1, b2, op;
        void'($urandom(32'h5EC0DE));
        for (int i = 0; i < DEPTH; i++) begin
            m_data[i] = '0;
            m_mask[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_chk++;
        if (dq_drive !== 1'b0 || err_fix !== 1'b0 || err_bad !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: drive/fix/bad actual %b/%b/%b expected 0/0/0", dq_drive, err_fix, err_bad);
        end
        rd_word(5, "R11");
        rd_word(DEPTH - 1, "R11");

        // R2: lane strobes in word view.
        wr_word(3, 16'hA5C3, 1'b0, 1'b0, "R2");
        wr_word(3, 16'h1111, 1'b1, 1'b0, "R2");
        rd_word(3, "R2");
        wr_word(3, 16'h7E00, 1'b0, 1'b1, "R2");
        rd_word(3, "R2");

        // R1: deselected writes store nothing.
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, 16'hFFFF, 1'b0, '0, "R1");
        do_op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, 16'hFFFF, 1'b0, '0, "R1");
        rd_word(3, "R1");

        // R4: write with output strobe low leaves bus quiet.
        do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9, 16'h1234, 1'b0, '0, "R4");
        rd_word(9, "R4");

        // R7: byte view on both lanes.
        do_op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 7'(21), 16'hFF5A, 1'b0, '0, "R7");
        do_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 7'(21), 16'h0, 1'b0, '0, "R7");
        do_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 7'(20), 16'h0, 1'b0, '0, "R7");
        rd_word(10, "R7");

        // R5 and R9: one-bit fault corrected on every read, never scrubbed.
        wr_word(12, 16'hBEEF, 1'b0, 1'b0, "R5");
        inject(12, 22'(1) << pos_of(3));
        rd_word(12, "R5");
        rd_word(12, "R9");
        rd_word(12, "R9");

        // R8: partial write corrects a fault in the other lane.
        wr_word(14, 16'hC0DE, 1'b0, 1'b0, "R8");
        inject(14, 22'(1) << pos_of(13));
        wr_word(14, 16'h0042, 1'b1, 1'b0, "R8");
        rd_word(14, "R8");

        // R6: two-bit fault returns stored data bits.
        wr_word(16, 16'h0F0F, 1'b0, 1'b0, "R6");
        inject(16, (22'(1) << pos_of(0)) | (22'(1) << pos_of(9)));
        rd_word(16, "R6");
        inject(17, 22'h000003);
        rd_word(17, "R6");

        // Constrained random mix.
        for (int n = 0; n < 4000; n++) begin
            op = int'($urandom_range(0, 9));
            w  = int'($urandom_range(0, DEPTH - 1));
            if (op == 6 && m_mask[w] == '0) begin
                b1 = int'($urandom_range(0, 21));
                m  = 22'(1) << b1;
                if ($urandom_range(0, 1) == 1) begin
                    b2 = (b1 + 1 + int'($urandom_range(0, 20))) % 22;
                    m  = m | (22'(1) << b2);
                end
                inject(w, m);
            end else if (op <= 2 || op == 8) begin
                if ($urandom_range(0, 2) == 0)
                    do_op(1'b0, 1'b1, 1'b0, (op == 8) ? 1'b0 : 1'b1, 1'($urandom), 1'($urandom),
                          1'b1, (AW+1)'($urandom), 16'($urandom), 1'b0, '0, "");
                else
                    do_op(1'b0, 1'b1, 1'b0, (op == 8) ? 1'b0 : 1'b1, 1'($urandom), 1'($urandom),
                          1'b0, (AW+1)'(w), 16'($urandom), 1'b0, '0, "");
            end else if (op == 7) begin
                do_op(1'($urandom), 1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0,
                      1'($urandom), (AW+1)'($urandom), 16'($urandom), 1'b0, '0, "R1");
            end else if (op == 9) begin
                do_op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, (AW+1)'(w), 16'h0, 1'b0, '0, "R3");
            end else begin
                do_op(1'b0, 1'b1, 1'b1, 1'b0, 1'($urandom), 1'($urandom),
                      1'($urandom), (AW+1)'($urandom), 16'h0, 1'b0, '0, "");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule